// File: doc/BRIEF.md
# Cartridge Bank Controller with Time Latch

This block sits on the cartridge side of a processor bus with 16-bit addresses and 8-bit data. A write in the lower half of the address space, 0x0000 to 0x7FFF, never reaches ROM. Instead it programs one of four control fields. Address bits [14:13] choose the field. One field gates external RAM on and off. One picks the switchable ROM bank. One steers the external window either to a RAM bank or to one of five clock registers. The last one freezes a snapshot of a wall-clock time input into those clock registers.

On the read side the block forms the ROM address for both ROM windows and the RAM address for the 0xA000 to 0xBFFF window. It also chooses the byte returned to the processor: ROM data, a clock register, RAM data, or the open-bus value 0xFF. All steering is combinational on the current address. Control fields change on the clock edge that samples a write, so the new setting applies from the next bus cycle. The block does not count time itself. It only captures the time inputs when a latch occurs.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the switchable ROM bank is 1, the RAM bank is 0, external RAM is gated off, no clock register is mapped, the snapshot state is clear, and all five clock registers hold 0x00.
- R2: A write of 0x0A anywhere in 0x0000-0x1FFF turns external RAM access on. A write of 0x00 there turns it off. Any other value leaves the gate as it was.
- R3: A write in 0x2000-0x3FFF sets the switchable ROM bank to the low 7 bits of the data. Bit 7 is ignored, and a low-7 value of 0 is turned into 1.
- R4: With ROM_BANKS a power of two, the stored bank is the (zero-corrected) bank number modulo ROM_BANKS. With the default of 64, a write of 0x45 selects bank 5 and a write of 0x40 selects bank 0.
- R5: A write in 0x4000-0x5FFF with data below 4 selects that RAM bank and unmaps the clock registers. The RAM address is {bank[1:0], addr[12:0]}.
- R6: A write in 0x4000-0x5FFF with data 0x08 to 0x0C maps clock register (data - 8) into the external window. Here 0 is seconds, 1 minutes, 2 hours, 3 day bits [7:0], and 4 the flag register. Data 0x04 to 0x07 and above 0x0C change nothing.
- R7: In 0x6000-0x7FFF, a write of 0x01 while not in the snapshot state takes a snapshot and enters that state. A write of 0x00 while in the snapshot state leaves it. Every other write there changes nothing, including a second 0x01.
- R8: A snapshot loads seconds, minutes, hours and day[7:0] into registers 0 to 3. It also sets register 4 to {its own bits [7:4], 3'b000, day[8]}.
- R9: For 0x0000-0x3FFF the ROM address is {zero bank bits, addr[13:0]}. For 0x4000-0x7FFF it is {selected bank, addr[13:0]}. For both ranges the returned byte is the ROM data input.
- R10: A read in 0xA000-0xBFFF returns the mapped clock register when one is mapped, whatever the RAM gate. Otherwise it returns the RAM data input when RAM is on, and 0xFF when neither applies.
- R11: A write in 0xA000-0xBFFF stores the full byte into the mapped clock register when one is mapped, with the RAM write strobe low. Otherwise it raises the RAM write strobe only when RAM is on.
- R12: Reads in 0x8000-0x9FFF and 0xC000-0xFFFF return 0xFF, and writes there never raise the RAM write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Processor address |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Byte returned to the processor |
| rom_rdata | input | 8 | Data from the ROM at rom_addr |
| rom_addr | output | ROM_BANK_W+14 | ROM byte address |
| ram_rdata | input | 8 | Data from the external RAM at ram_addr |
| ram_addr | output | 15 | External RAM byte address |
| ram_we | output | 1 | External RAM write strobe |
| time_sec | input | 8 | Seconds value to capture |
| time_min | input | 8 | Minutes value to capture |
| time_hour | input | 8 | Hours value to capture |
| time_day | input | 9 | Day count to capture |

## Verification
Every address-driven result depends only on the current address and on state held in registers. This covers bus_rdata, rom_addr, ram_addr and ram_we, and they are due in the same cycle the address is presented. A control write takes effect at the clock edge that samples it, so it is visible from the next bus cycle. The bench drives each bus cycle just after a falling edge and samples the outputs shortly before the next rising edge. It never probes within the cycle of the write whose effect it checks. Write strobe probes are sampled in the write's own cycle, because ram_we is combinational.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
package cbc_pkg;

    // Control field chosen by address bits [14:13] of a lower-half write.
    typedef enum logic [1:0] {
        CF_RAM_GATE = 2'd0,
        CF_ROM_SEL  = 2'd1,
        CF_WIN_SEL  = 2'd2,
        CF_SNAPSHOT = 2'd3
    } ctl_field_e;

    // Coarse decode of the bus address (bits [15:13]).
    typedef enum logic [1:0] {
        RG_ROM_FIXED,
        RG_ROM_SWITCH,
        RG_WINDOW,
        RG_OTHER
    } region_e;

    typedef struct packed {
        logic [8:0] day;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
    } wall_time_t;

    localparam int CLK_REGS   = 5;
    localparam int CLK_IDX_W  = 3;
    localparam int RAM_BANK_W = 2;
    localparam int WIN_OFS_W  = 13;
    localparam int ROM_OFS_W  = 14;
    localparam int RAM_ADDR_W = RAM_BANK_W + WIN_OFS_W;

    localparam logic [7:0] OPEN_BUS     = 8'hFF;
    localparam logic [7:0] RAM_ON_CODE  = 8'h0A;
    localparam logic [7:0] RAM_OFF_CODE = 8'h00;
    localparam logic [7:0] CLK_SEL_LO   = 8'h08;
    localparam logic [7:0] CLK_SEL_HI   = 8'h0C;
    localparam logic [7:0] RAM_SEL_LIM  = 8'h04;
    localparam logic [7:0] SNAP_TAKE    = 8'h01;
    localparam logic [7:0] SNAP_RELEASE = 8'h00;

    function automatic region_e region_of(input logic [2:0] top3);
        region_e r;
        if (!top3[2])           r = top3[1] ? RG_ROM_SWITCH : RG_ROM_FIXED;
        else if (top3 == 3'b101) r = RG_WINDOW;
        else                    r = RG_OTHER;
        return r;
    endfunction

    function automatic logic [6:0] bank_no_zero(input logic [6:0] v);
        return (v == 7'd0) ? 7'd1 : v;
    endfunction

endpackage

// File: rtl/cbc_ctrl_regs.sv
`timescale 1ns/1ps
module cbc_ctrl_regs
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS  = 64,
    parameter int ROM_BANK_W = $clog2(ROM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_wr,
    input  logic [1:0]             ctl_field,
    input  logic [7:0]             wdata,
    output logic                   ram_en,
    output logic [ROM_BANK_W-1:0]  rom_bank,
    output logic [RAM_BANK_W-1:0]  ram_bank,
    output logic                   clk_map,
    output logic [CLK_IDX_W-1:0]   clk_idx,
    output logic                   snap_held,
    output logic                   snap_take
);

    ctl_field_e             field;
    logic [6:0]             bank7;
    logic [ROM_BANK_W-1:0]  bank_wrapped;
    logic                   sel_ram, sel_clk;

    assign field = ctl_field_e'(ctl_field);
    assign bank7 = bank_no_zero(wdata[6:0]);

    // Power-of-two bank count: modulo is a plain truncation or extension.
    generate
        if (ROM_BANK_W < 7) begin : g_wrap_trunc
            assign bank_wrapped = bank7[ROM_BANK_W-1:0];
        end else if (ROM_BANK_W == 7) begin : g_wrap_exact
            assign bank_wrapped = bank7;
        end else begin : g_wrap_extend
            assign bank_wrapped = {{(ROM_BANK_W-7){1'b0}}, bank7};
        end
    endgenerate

    assign sel_ram   = (wdata < RAM_SEL_LIM);
    assign sel_clk   = (wdata >= CLK_SEL_LO) && (wdata <= CLK_SEL_HI);
    assign snap_take = ctl_wr && (field == CF_SNAPSHOT) && (wdata == SNAP_TAKE) && !snap_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_en    <= 1'b0;
            rom_bank  <= ROM_BANK_W'(1);
            ram_bank  <= '0;
            clk_map   <= 1'b0;
            clk_idx   <= '0;
            snap_held <= 1'b0;
        end else if (ctl_wr) begin
            unique case (field)
                CF_RAM_GATE: begin
                    if (wdata == RAM_ON_CODE)       ram_en <= 1'b1;
                    else if (wdata == RAM_OFF_CODE) ram_en <= 1'b0;
                end
                CF_ROM_SEL: rom_bank <= bank_wrapped;
                CF_WIN_SEL: begin
                    if (sel_ram) begin
                        ram_bank <= wdata[RAM_BANK_W-1:0];
                        clk_map  <= 1'b0;
                    end else if (sel_clk) begin
                        clk_idx  <= wdata[CLK_IDX_W-1:0];
                        clk_map  <= 1'b1;
                    end
                end
                CF_SNAPSHOT: begin
                    if (snap_take)
                        snap_held <= 1'b1;
                    else if (snap_held && wdata == SNAP_RELEASE)
                        snap_held <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cbc_clock_file.sv
`timescale 1ns/1ps
module cbc_clock_file
    import cbc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          snap_take,
    input  wall_time_t                    now,
    input  logic                          reg_we,
    input  logic [CLK_IDX_W-1:0]          reg_idx,
    input  logic [7:0]                    reg_wdata,
    output logic [CLK_REGS-1:0][7:0]      file_q,
    output logic [7:0]                    reg_rdata
);

    logic [CLK_REGS-1:0][7:0] snap_val;

    always_comb begin
        snap_val[0] = now.second;
        snap_val[1] = now.minute;
        snap_val[2] = now.hour;
        snap_val[3] = now.day[7:0];
        snap_val[4] = {file_q[4][7:4], 3'b000, now.day[8]};
    end

    generate
        for (genvar i = 0; i < CLK_REGS; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    file_q[i] <= 8'h00;
                else if (snap_take)
                    file_q[i] <= snap_val[i];
                else if (reg_we && reg_idx == CLK_IDX_W'(i))
                    file_q[i] <= reg_wdata;
            end
        end
    endgenerate

    always_comb begin
        reg_rdata = OPEN_BUS;
        for (int i = 0; i < CLK_REGS; i++)
            if (reg_idx == CLK_IDX_W'(i)) reg_rdata = file_q[i];
    end

endmodule

// File: rtl/cbc_bus_steer.sv
`timescale 1ns/1ps
module cbc_bus_steer
    import cbc_pkg::*;
#(
    parameter int ROM_BANK_W = 6,
    parameter int ROM_ADDR_W = ROM_BANK_W + ROM_OFS_W
) (
    input  logic [15:0]             addr,
    input  logic                    wr,
    input  logic                    ram_en,
    input  logic                    clk_map,
    input  logic [ROM_BANK_W-1:0]   rom_bank,
    input  logic [RAM_BANK_W-1:0]   ram_bank,
    input  logic [7:0]              rom_rdata,
    input  logic [7:0]              ram_rdata,
    input  logic [7:0]              clk_rdata,
    output logic [7:0]              rdata,
    output logic [ROM_ADDR_W-1:0]   rom_addr,
    output logic [RAM_ADDR_W-1:0]   ram_addr,
    output logic                    ram_we,
    output logic                    clk_we,
    output logic                    ctl_wr
);

    region_e region;

    assign region   = region_of(addr[15:13]);
    assign ram_addr = {ram_bank, addr[WIN_OFS_W-1:0]};
    assign ctl_wr   = wr && !addr[15];
    assign clk_we   = wr && (region == RG_WINDOW) && clk_map;
    assign ram_we   = wr && (region == RG_WINDOW) && !clk_map && ram_en;

    always_comb begin
        rom_addr = {{ROM_BANK_W{1'b0}}, addr[ROM_OFS_W-1:0]};
        if (region == RG_ROM_SWITCH)
            rom_addr = {rom_bank, addr[ROM_OFS_W-1:0]};
    end

    always_comb begin
        unique case (region)
            RG_ROM_FIXED, RG_ROM_SWITCH: rdata = rom_rdata;
            RG_WINDOW: begin
                if (clk_map)     rdata = clk_rdata;
                else if (ram_en) rdata = ram_rdata;
                else             rdata = OPEN_BUS;
            end
            default: rdata = OPEN_BUS;
        endcase
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
`timescale 1ns/1ps
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS  = 64,
    parameter int ROM_BANK_W = $clog2(ROM_BANKS),
    parameter int ROM_ADDR_W = ROM_BANK_W + ROM_OFS_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [15:0]             bus_addr,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [7:0]              rom_rdata,
    output logic [ROM_ADDR_W-1:0]   rom_addr,
    input  logic [7:0]              ram_rdata,
    output logic [RAM_ADDR_W-1:0]   ram_addr,
    output logic                    ram_we,
    input  logic [7:0]              time_sec,
    input  logic [7:0]              time_min,
    input  logic [7:0]              time_hour,
    input  logic [8:0]              time_day
);

    logic                      ram_en_q, clk_map_q, snap_held_q, snap_take;
    logic [ROM_BANK_W-1:0]     rom_bank_q;
    logic [RAM_BANK_W-1:0]     ram_bank_q;
    logic [CLK_IDX_W-1:0]      clk_idx_q;
    logic                      ctl_wr, clk_we;
    logic [7:0]                clk_rdata;
    logic [CLK_REGS-1:0][7:0]  clk_file;
    wall_time_t                now;

    assign now = '{day: time_day, hour: time_hour, minute: time_min, second: time_sec};

    cbc_bus_steer #(.ROM_BANK_W(ROM_BANK_W), .ROM_ADDR_W(ROM_ADDR_W)) u_steer (
        .addr      (bus_addr),
        .wr        (bus_wr),
        .ram_en    (ram_en_q),
        .clk_map   (clk_map_q),
        .rom_bank  (rom_bank_q),
        .ram_bank  (ram_bank_q),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .clk_rdata (clk_rdata),
        .rdata     (bus_rdata),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .clk_we    (clk_we),
        .ctl_wr    (ctl_wr)
    );

    cbc_ctrl_regs #(.ROM_BANKS(ROM_BANKS), .ROM_BANK_W(ROM_BANK_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_field (bus_addr[14:13]),
        .wdata     (bus_wdata),
        .ram_en    (ram_en_q),
        .rom_bank  (rom_bank_q),
        .ram_bank  (ram_bank_q),
        .clk_map   (clk_map_q),
        .clk_idx   (clk_idx_q),
        .snap_held (snap_held_q),
        .snap_take (snap_take)
    );

    cbc_clock_file u_clock (
        .clk       (clk),
        .rst       (rst),
        .snap_take (snap_take),
        .now       (now),
        .reg_we    (clk_we),
        .reg_idx   (clk_idx_q),
        .reg_wdata (bus_wdata),
        .file_q    (clk_file),
        .reg_rdata (clk_rdata)
    );

endmodule

// File: rtl/cbc_checker.sv
`timescale 1ns/1ps
module cbc_checker
    import cbc_pkg::*;
#(
    parameter int ROM_BANK_W = 6,
    parameter int ROM_ADDR_W = ROM_BANK_W + ROM_OFS_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic [15:0]               bus_addr,
    input logic                      bus_wr,
    input logic [7:0]                bus_wdata,
    input logic [7:0]                bus_rdata,
    input logic [ROM_ADDR_W-1:0]     rom_addr,
    input logic                      ram_we,
    input logic [8:0]                time_day,
    input logic [7:0]                time_sec,
    input logic                      ram_en,
    input logic                      clk_map,
    input logic [ROM_BANK_W-1:0]     rom_bank,
    input logic                      snap_held,
    input logic                      snap_take,
    input logic [CLK_REGS-1:0][7:0]  clk_file
);

    logic in_window;
    assign in_window = (bus_addr[15:13] == 3'b101);

    assert_ram_on_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[15:13] == 3'b000 && bus_wdata == 8'h0A) |=> ram_en);

    assert_bank_zero_fix_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[15:13] == 3'b001 && bus_wdata[6:0] == 7'd0) |=> (rom_bank == ROM_BANK_W'(1)));

    assert_fixed_rom_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[15:14] == 2'b00) |-> (rom_addr[ROM_ADDR_W-1:ROM_OFS_W] == '0));

    assert_switch_rom_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[15:14] == 2'b01) |-> (rom_addr[ROM_ADDR_W-1:ROM_OFS_W] == rom_bank));

    assert_open_bus_R10: assert property (@(posedge clk) disable iff (rst)
        (in_window && !clk_map && !ram_en) |-> (bus_rdata == 8'hFF));

    assert_ram_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (bus_wr && in_window && ram_en && !clk_map));

    assert_outside_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[15] && !in_window) |-> (!ram_we && bus_rdata == 8'hFF));

    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (snap_held && bus_wr && bus_addr[15:13] == 3'b011) |=> $stable(clk_file));

    assert_snap_load_R8: assert property (@(posedge clk) disable iff (rst)
        snap_take |=> (clk_file[0] == $past(time_sec) && clk_file[4][0] == $past(time_day[8])
                       && clk_file[4][7:4] == $past(clk_file[4][7:4]) && snap_held));

endmodule

bind cart_bank_ctrl cbc_checker #(.ROM_BANK_W(ROM_BANK_W), .ROM_ADDR_W(ROM_ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rom_addr  (rom_addr),
    .ram_we    (ram_we),
    .time_day  (time_day),
    .time_sec  (time_sec),
    .ram_en    (ram_en_q),
    .clk_map   (clk_map_q),
    .rom_bank  (rom_bank_q),
    .snap_held (snap_held_q),
    .snap_take (snap_take),
    .clk_file  (clk_file)
);

// File: tb/tb_cart_bank_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctrl;

    localparam int RB = 64;
    localparam int BW = 6;
    localparam int AW = BW + 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   bus_addr = 16'h0000;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [7:0]    rom_rdata, ram_rdata;
    logic [AW-1:0] rom_addr;
    logic [14:0]   ram_addr;
    logic          ram_we;
    logic [7:0]    time_sec = 8'h00, time_min = 8'h00, time_hour = 8'h00;
    logic [8:0]    time_day = 9'h000;

    always #4 clk = ~clk;   // 125 MHz

    // Simple memory models: byte depends on address so sources are distinguishable.
    assign rom_rdata = bus_addr[7:0] ^ 8'hA5;
    assign ram_rdata = bus_addr[7:0] ^ 8'h3C;

    cart_bank_ctrl #(.ROM_BANKS(RB)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rom_rdata(rom_rdata), .rom_addr(rom_addr),
        .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
        .time_sec(time_sec), .time_min(time_min), .time_hour(time_hour), .time_day(time_day)
    );

    typedef struct {
        bit            use_rd;  logic [7:0]    rd;
        bit            use_rom; logic [AW-1:0] rom;
        bit            use_ram; logic [14:0]   ram;
        bit            use_we;  logic          we;
        string         tag;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    function automatic logic [7:0] rom_byte(input logic [15:0] a); return a[7:0] ^ 8'hA5; endfunction
    function automatic logic [7:0] ram_byte(input logic [15:0] a); return a[7:0] ^ 8'h3C; endfunction
    function automatic logic [AW-1:0] rom_at(input int bank, input logic [15:0] a);
        return {BW'(bank), a[13:0]};
    endfunction

    // ---------------- driver ----------------
    task automatic drive(input logic [15:0] a, input logic w, input logic [7:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wr = w; bus_wdata = d;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        drive(a, 1'b1, d);
    endtask

    task automatic push(input exp_t e); sbq.push_back(e); endtask

    task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp_rd, input string tag);
        exp_t e;
        drive(a, 1'b0, 8'h00);
        e = '{use_rd:1, rd:exp_rd, use_rom:0, rom:'0, use_ram:0, ram:'0, use_we:0, we:0, tag:tag};
        push(e);
    endtask

    task automatic rom_chk(input logic [15:0] a, input int bank, input string tag);
        exp_t e;
        drive(a, 1'b0, 8'h00);
        e = '{use_rd:1, rd:rom_byte(a), use_rom:1, rom:rom_at(bank, a), use_ram:0, ram:'0,
              use_we:0, we:0, tag:tag};
        push(e);
    endtask

    task automatic ram_chk(input logic [15:0] a, input logic [1:0] bank, input string tag);
        exp_t e;
        drive(a, 1'b0, 8'h00);
        e = '{use_rd:1, rd:ram_byte(a), use_rom:0, rom:'0, use_ram:1, ram:{bank, a[12:0]},
              use_we:0, we:0, tag:tag};
        push(e);
    endtask

    task automatic we_chk(input logic [15:0] a, input logic [7:0] d, input logic exp_we, input string tag);
        exp_t e;
        drive(a, 1'b1, d);
        e = '{use_rd:0, rd:'0, use_rom:0, rom:'0, use_ram:0, ram:'0, use_we:1, we:exp_we, tag:tag};
        push(e);
    endtask

    // ---------------- monitor ----------------
    initial begin
        forever begin
            @(negedge clk); #3;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                if (e.use_rd) begin
                    checks++;
                    if (bus_rdata !== e.rd) begin
                        errors++;
                        $display("FAIL %s: rdata actual %02h expected %02h", e.tag, bus_rdata, e.rd);
                    end
                end
                if (e.use_rom) begin
                    checks++;
                    if (rom_addr !== e.rom) begin
                        errors++;
                        $display("FAIL %s: rom_addr actual %05h expected %05h", e.tag, rom_addr, e.rom);
                    end
                end
                if (e.use_ram) begin
                    checks++;
                    if (ram_addr !== e.ram) begin
                        errors++;
                        $display("FAIL %s: ram_addr actual %04h expected %04h", e.tag, ram_addr, e.ram);
                    end
                end
                if (e.use_we) begin
                    checks++;
                    if (ram_we !== e.we) begin
                        errors++;
                        $display("FAIL %s: ram_we actual %0b expected %0b", e.tag, ram_we, e.we);
                    end
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run not finished, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        // R1: reset state observed at the ports
        rom_chk(16'h4123, 1, "R1 rom bank after reset");
        rd_chk (16'hA010, 8'hFF, "R1 ram off after reset");
        we_chk (16'hA010, 8'h11, 1'b0, "R1 no ram strobe after reset");
        wr(16'h0000, 8'h0A);
        ram_chk(16'hA020, 2'd0, "R1 ram bank 0 after reset");
        wr(16'h0000, 8'h00);

        // R9: fixed window uses bank 0 bits
        rom_chk(16'h1234, 0, "R9 fixed rom window");
        rom_chk(16'h3FFF, 0, "R9 fixed rom top");

        // R2: RAM gate codes
        wr(16'h1FFF, 8'h0A);
        ram_chk(16'hB0F0, 2'd0, "R2 ram on via 0x0A");
        wr(16'h0800, 8'h05);
        ram_chk(16'hA001, 2'd0, "R2 other value keeps gate");
        wr(16'h0000, 8'h00);
        rd_chk (16'hA001, 8'hFF, "R2 ram off via 0x00");
        wr(16'h0000, 8'h0A);

        // R3: ROM bank select
        wr(16'h2000, 8'h85);
        rom_chk(16'h7FFF, 5, "R3 bank low 7 bits");
        wr(16'h3FFF, 8'h00);
        rom_chk(16'h4000, 1, "R3 zero becomes one");
        wr(16'h2100, 8'h80);
        rom_chk(16'h5555, 1, "R3 bit7 only becomes one");
        wr(16'h2000, 8'h3F);
        rom_chk(16'h6ABC, 63, "R3 highest bank");

        // R4: modulo wrap
        wr(16'h3000, 8'h45);
        rom_chk(16'h4321, 5, "R4 wrap 0x45");
        wr(16'h3000, 8'h40);
        rom_chk(16'h4321, 0, "R4 wrap to bank 0");

        // R5: RAM bank select
        wr(16'h4000, 8'h03);
        ram_chk(16'hA155, 2'd3, "R5 ram bank 3");
        wr(16'h5000, 8'h04);
        ram_chk(16'hA155, 2'd3, "R5 value 4 ignored");
        wr(16'h5FFF, 8'h07);
        ram_chk(16'hBFFF, 2'd3, "R5 value 7 ignored");
        we_chk (16'hA200, 8'h99, 1'b1, "R11 ram strobe when on");

        // R6: clock register mapping and direct writes
        wr(16'h4000, 8'h08);
        rd_chk (16'hA000, 8'h00, "R6 reg0 mapped reset value");
        we_chk (16'hA000, 8'h77, 1'b0, "R11 no ram strobe when clock mapped");
        rd_chk (16'hB123, 8'h77, "R11 clock reg stores write");
        wr(16'h4000, 8'h0D);
        rd_chk (16'hA000, 8'h77, "R6 value 0x0D ignored");

        // R10: clock has priority over RAM gate state
        wr(16'h0000, 8'h00);
        rd_chk (16'hA000, 8'h77, "R10 clock read with ram off");
        wr(16'h0000, 8'h0A);

        // R8: snapshot contents
        time_sec = 8'h12; time_min = 8'h34; time_hour = 8'h05; time_day = 9'h1AB;
        wr(16'h4000, 8'h0C);
        wr(16'hA000, 8'hFE);
        rd_chk (16'hA000, 8'hFE, "R6 reg4 writable");
        wr(16'h6000, 8'h01);
        rd_chk (16'hA000, 8'hF1, "R8 reg4 upper kept day bit8");
        wr(16'h4000, 8'h08);
        rd_chk (16'hA000, 8'h12, "R8 seconds");
        wr(16'h4000, 8'h09);
        rd_chk (16'hA000, 8'h34, "R8 minutes");
        wr(16'h4000, 8'h0A);
        rd_chk (16'hA000, 8'h05, "R8 hours");
        wr(16'h4000, 8'h0B);
        rd_chk (16'hA000, 8'hAB, "R8 day low");

        // R7: sequence rules
        time_sec = 8'h20; time_day = 9'h044;
        wr(16'h4000, 8'h08);
        wr(16'h7FFF, 8'h01);
        rd_chk (16'hA000, 8'h12, "R7 second take ignored while held");
        wr(16'h6000, 8'h02);
        wr(16'h6000, 8'h01);
        rd_chk (16'hA000, 8'h12, "R7 other value does not release");
        wr(16'h6000, 8'h00);
        rd_chk (16'hA000, 8'h12, "R7 release keeps contents");
        wr(16'h6000, 8'h01);
        rd_chk (16'hA000, 8'h20, "R7 take after release");
        wr(16'h4000, 8'h0C);
        rd_chk (16'hA000, 8'hF0, "R8 reg4 day bit8 clear");

        // R5: RAM select unmaps clock
        wr(16'h4000, 8'h02);
        ram_chk(16'hA0C3, 2'd2, "R5 ram bank 2 unmaps clock");

        // R12: outside ranges
        rd_chk (16'h8000, 8'hFF, "R12 0x8000 open");
        rd_chk (16'hC123, 8'hFF, "R12 0xC123 open");
        we_chk (16'hC000, 8'h55, 1'b0, "R12 no strobe outside window");
        we_chk (16'h9FFF, 8'h55, 1'b0, "R12 no strobe below window");

        drive(16'h0000, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule